// File: doc/BRIEF.md
# Codec Sample Clock Generator

This block produces the bit-clock strobe and the frame-start strobe for the serial port of an audio or modem codec. Everything runs on one system clock. The two clock sources arrive as enable pulses on that clock: one is derived from a crystal, the other is an external master clock. When the crystal source is selected, a chain of two programmable dividers (ratio M, then ratio Q) turns crystal pulses into bit-clock strobes. When the external source is selected, each external pulse is itself a bit-clock strobe. A frame counter then divides the bit-clock strobes by an oversampling ratio OVER.

Two strap inputs pick one of four roles. `clk_mode` picks the source: crystal when it is 1, external when it is 0. `mode_ms` picks the frame-start owner: the block drives frame start when it is 1, and the host drives it when it is 0. In the two host-driven roles the block aligns its frame counter to each incoming frame start and flags any that arrive with the wrong spacing. A slot-select input, together with a slot-active output, lets two such blocks share one serial bus in adjacent 16-bit timeslots.

Top module: `codec_clkgen`

## Requirements
- R1: When `mode_ms`=1, consecutive `fs_out` strobes are exactly OVER bit strobes apart. OVER = 32 + 16·`over_sel`.
- R2: When `clk_mode`=1, `bclk_stb` pulses once for every M·Q `xtal_en` pulses, one cycle after the pulse that completes the count. M = `ratio_cfg[2:0]`+1 and Q = `ratio_cfg[5:3]`+1. In this mode `mclk_en` has no effect.
- R3: When `clk_mode`=0, each `mclk_en` pulse produces a `bclk_stb` pulse one cycle later. In this mode `xtal_en` has no effect.
- R4: When `mode_ms`=1, the first bit strobe after a reset or a configuration change carries `fs_out`. `fs_out` is always a single-cycle pulse that coincides with `bclk_stb`. `fs_in` has no effect in this mode.
- R5: When `mode_ms`=0, `fs_out` stays 0. The frame counter starts, and restarts at bit 0, when `fs_in` is high in a cycle that produces a bit strobe.
- R6: When `mode_ms`=0, `frame_err` pulses together with `bclk_stb` if `fs_in` arrives at any bit count other than OVER after the previous accepted frame start. The counter still resynchronises to the new frame start.
- R7: A change to `clk_mode`, `mode_ms`, `ratio_cfg` or `over_sel` clears every output on the next cycle and restarts all divider counters. No strobe from the old period follows.
- R8: `slot_active` is evaluated on each bit strobe and holds between strobes. It is high while the frame bit index lies in 16·`slot_sel` … 16·`slot_sel`+15, and only once a frame has started.
- R9: While `rst_n` is low, all outputs are 0.
- R10: When `mode_ms`=0, the first accepted `fs_in` after a reset or a configuration change never raises `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_en | input | 1 | Crystal-derived source pulse |
| mclk_en | input | 1 | External master-clock pulse |
| clk_mode | input | 1 | 1: crystal source through M/Q dividers; 0: external pulses |
| mode_ms | input | 1 | 1: block drives frame start; 0: host drives frame start |
| ratio_cfg | input | 6 | [2:0] = M−1, [5:3] = Q−1 |
| over_sel | input | 3 | Oversampling select, OVER = 32 + 16·value |
| fs_in | input | 1 | Host frame start, sampled in bit-strobe cycles |
| slot_sel | input | 1 | Timeslot for this unit: 0 or 1 |
| bclk_stb | output | 1 | Bit-clock strobe |
| fs_out | output | 1 | Frame-start strobe (roles with mode_ms=1) |
| frame_err | output | 1 | Misplaced host frame start |
| slot_active | output | 1 | Selected timeslot is in progress |

## Verification
Every output is registered. Each output therefore reflects the inputs sampled at one rising edge and changes at that same edge, so it is visible one clock period after the cycle in which the stimulus was presented. The bench drives inputs on falling edges. Its reference model advances on the same rising edge the design uses and is compared 2 ns later, so no comparison can land before a result is due. A configuration change is therefore expected to show as cleared outputs at the first rising edge that sees it. An early host frame start is expected to show `frame_err` in the same cycle as the bit strobe it produced.

// File: rtl/codec_clkgen_pkg.sv
package codec_clkgen_pkg;

   // Role encoding: {clk_mode, mode_ms}
   typedef enum logic [1:0] {
      ROLE_EXT_SLAVE  = 2'b00,
      ROLE_EXT_MASTER = 2'b01,
      ROLE_XTL_SLAVE  = 2'b10,
      ROLE_XTL_MASTER = 2'b11
   } ckg_role_t;

   function automatic logic role_is_master(ckg_role_t r);
      return (r == ROLE_EXT_MASTER) || (r == ROLE_XTL_MASTER);
   endfunction

   function automatic logic role_uses_xtal(ckg_role_t r);
      return (r == ROLE_XTL_SLAVE) || (r == ROLE_XTL_MASTER);
   endfunction

endpackage

// File: rtl/ckg_div_chain.sv
// Cascade of programmable divide-by-(ratio+1) stages on an enable pulse.
module ckg_div_chain #(
   parameter int N_STAGES = 2,
   parameter int STAGE_W  = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        src_en,
   input  logic [N_STAGES*STAGE_W-1:0] ratios_m1,
   output logic                        out_stb
);
   logic [N_STAGES:0] en_c;
   assign en_c[0] = src_en;

   for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
      logic [STAGE_W-1:0] cnt;
      logic [STAGE_W-1:0] lim;
      assign lim = ratios_m1[g*STAGE_W +: STAGE_W];
      assign en_c[g+1] = en_c[g] && (cnt == lim);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (clr)        cnt <= '0;
         else if (en_c[g])    cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
      end
   end

   assign out_stb = en_c[N_STAGES];
endmodule

// File: rtl/ckg_frame_ctr.sv
// Frame bit counter: self-timed when master, aligned to host frame start when slave.
module ckg_frame_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic          is_master,
   input  logic          fs_in,
   input  logic [CW-1:0] over_m1,
   output logic          fs_out,
   output logic          frame_err,
   output logic          valid_nxt,
   output logic [CW-1:0] idx_nxt
);
   logic [CW-1:0] idx;
   logic          valid;
   logic          fs_nxt, err_nxt;
   logic          at_end;

   assign at_end = (idx == over_m1);

   always_comb begin
      idx_nxt   = idx;
      valid_nxt = valid;
      fs_nxt    = 1'b0;
      err_nxt   = 1'b0;
      if (tick) begin
         if (is_master) begin
            if (!valid) begin
               valid_nxt = 1'b1;
               idx_nxt   = '0;
               fs_nxt    = 1'b1;
            end else begin
               idx_nxt = at_end ? '0 : idx + 1'b1;
               fs_nxt  = at_end;
            end
         end else if (fs_in) begin
            err_nxt   = valid && !at_end;
            idx_nxt   = '0;
            valid_nxt = 1'b1;
         end else if (valid) begin
            idx_nxt = at_end ? '0 : idx + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0; valid <= 1'b0; fs_out <= 1'b0; frame_err <= 1'b0;
      end else if (clr) begin
         idx <= '0; valid <= 1'b0; fs_out <= 1'b0; frame_err <= 1'b0;
      end else begin
         idx       <= idx_nxt;
         valid     <= valid_nxt;
         fs_out    <= fs_nxt;
         frame_err <= err_nxt;
      end
   end
endmodule

// File: rtl/ckg_slot_win.sv
// Timeslot window decode, refreshed on each bit strobe.
module ckg_slot_win #(
   parameter int CW        = 8,
   parameter int SLOT_BITS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic          valid_nxt,
   input  logic [CW-1:0] idx_nxt,
   input  logic          slot_sel,
   output logic          slot_active
);
   localparam logic [CW:0] SLOT_LEN = (CW+1)'(SLOT_BITS);

   logic [CW:0] lo, hi, pos;
   logic        in_win;

   assign lo     = slot_sel ? SLOT_LEN : '0;
   assign hi     = lo + SLOT_LEN;
   assign pos    = {1'b0, idx_nxt};
   assign in_win = valid_nxt && (pos >= lo) && (pos < hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_active <= 1'b0;
      else if (clr)   slot_active <= 1'b0;
      else if (tick)  slot_active <= in_win;
   end
endmodule

// File: rtl/codec_clkgen.sv
module codec_clkgen
   import codec_clkgen_pkg::*;
#(
   parameter int STAGE_W   = 3,
   parameter int N_STAGES  = 2,
   parameter int OSEL_W    = 3,
   parameter int OVER_BASE = 32,
   parameter int OVER_STEP = 16,
   parameter int SLOT_BITS = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        xtal_en,
   input  logic                        mclk_en,
   input  logic                        clk_mode,
   input  logic                        mode_ms,
   input  logic [N_STAGES*STAGE_W-1:0] ratio_cfg,
   input  logic [OSEL_W-1:0]           over_sel,
   input  logic                        fs_in,
   input  logic                        slot_sel,
   output logic                        bclk_stb,
   output logic                        fs_out,
   output logic                        frame_err,
   output logic                        slot_active
);
   localparam int OVER_MAX = OVER_BASE + OVER_STEP * ((1 << OSEL_W) - 1);
   localparam int CW       = $clog2(OVER_MAX);
   localparam int CFG_W    = 2 + N_STAGES*STAGE_W + OSEL_W;

   if (OVER_BASE < 2*SLOT_BITS) begin : g_chk_over
      $error("OVER_BASE must cover two timeslots");
   end
   if (N_STAGES < 1 || STAGE_W < 1) begin : g_chk_div
      $error("divider chain needs at least one stage of one bit");
   end
   if (OVER_STEP < 0) begin : g_chk_step
      $error("OVER_STEP must not be negative");
   end

   ckg_role_t      role;
   logic [CFG_W-1:0] cfg_now, cfg_q;
   logic           cfg_chg;
   logic           use_xtal, master;
   logic           chain_stb, tick;
   logic [CW-1:0]  over_m1;
   logic           valid_nxt;
   logic [CW-1:0]  idx_nxt;

   assign role     = ckg_role_t'({clk_mode, mode_ms});
   assign use_xtal = role_uses_xtal(role);
   assign master   = role_is_master(role);
   assign cfg_now  = {clk_mode, mode_ms, ratio_cfg, over_sel};
   assign cfg_chg  = (cfg_now != cfg_q);
   assign over_m1  = CW'(OVER_BASE - 1 + OVER_STEP * int'(over_sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   ckg_div_chain #(.N_STAGES(N_STAGES), .STAGE_W(STAGE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(cfg_chg),
      .src_en(xtal_en && use_xtal), .ratios_m1(ratio_cfg),
      .out_stb(chain_stb)
   );

   assign tick = use_xtal ? chain_stb : mclk_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bclk_stb <= 1'b0;
      else if (cfg_chg) bclk_stb <= 1'b0;
      else              bclk_stb <= tick;
   end

   ckg_frame_ctr #(.CW(CW)) u_frame (
      .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .tick(tick && !cfg_chg),
      .is_master(master), .fs_in(fs_in), .over_m1(over_m1),
      .fs_out(fs_out), .frame_err(frame_err),
      .valid_nxt(valid_nxt), .idx_nxt(idx_nxt)
   );

   ckg_slot_win #(.CW(CW), .SLOT_BITS(SLOT_BITS)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .tick(tick),
      .valid_nxt(valid_nxt), .idx_nxt(idx_nxt), .slot_sel(slot_sel),
      .slot_active(slot_active)
   );
endmodule

// File: rtl/codec_clkgen_chk.sv
module codec_clkgen_chk #(
   parameter int STAGE_W   = 3,
   parameter int N_STAGES  = 2,
   parameter int OSEL_W    = 3,
   parameter int OVER_BASE = 32,
   parameter int OVER_STEP = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        clk_mode,
   input logic                        mode_ms,
   input logic [N_STAGES*STAGE_W-1:0] ratio_cfg,
   input logic [OSEL_W-1:0]           over_sel,
   input logic                        fs_in,
   input logic                        bclk_stb,
   input logic                        fs_out,
   input logic                        frame_err,
   input logic                        slot_active
);
   localparam int CFG_W = 2 + N_STAGES*STAGE_W + OSEL_W;

   logic [CFG_W-1:0] cfg_now, cfg_prev;
   logic [15:0]      gap;
   logic             seen;
   logic             same_cfg;

   assign cfg_now  = {clk_mode, mode_ms, ratio_cfg, over_sel};
   assign same_cfg = (cfg_now == cfg_prev);

   // Independent count of bit strobes between frame starts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_prev <= '0; gap <= '0; seen <= 1'b0;
      end else begin
         cfg_prev <= cfg_now;
         if (!same_cfg || !mode_ms) begin
            seen <= 1'b0; gap <= '0;
         end else if (fs_out) begin
            seen <= 1'b1; gap <= '0;
         end else if (bclk_stb) begin
            gap <= gap + 16'd1;
         end
      end
   end

   // R1
   a_r1_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_out && seen && same_cfg && mode_ms) |->
         (int'(gap) == OVER_BASE - 1 + OVER_STEP * int'(over_sel)));

   // R4
   a_r4_fs_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
      fs_out |-> bclk_stb);

   // R5
   a_r5_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_ms) |-> !fs_out);

   // R6
   a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> (bclk_stb && !$past(mode_ms) && $past(fs_in)));

   // R7
   a_r7_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !same_cfg) |=>
         (!bclk_stb && !fs_out && !frame_err && !slot_active));
endmodule

bind codec_clkgen codec_clkgen_chk #(
   .STAGE_W(STAGE_W), .N_STAGES(N_STAGES), .OSEL_W(OSEL_W),
   .OVER_BASE(OVER_BASE), .OVER_STEP(OVER_STEP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .mode_ms(mode_ms),
   .ratio_cfg(ratio_cfg), .over_sel(over_sel), .fs_in(fs_in),
   .bclk_stb(bclk_stb), .fs_out(fs_out), .frame_err(frame_err),
   .slot_active(slot_active)
);

// File: tb/codec_clkgen_tb.sv
module codec_clkgen_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xtal_en = 1'b0, mclk_en = 1'b0, clk_mode = 1'b1, mode_ms = 1'b1;
   logic [5:0] ratio_cfg = 6'd0;
   logic [2:0] over_sel = 3'd0;
   logic fs_in = 1'b0, slot_sel = 1'b0;
   logic bclk_stb, fs_out, frame_err, slot_active;

   always #4 clk = ~clk;   // 125 MHz

   codec_clkgen u_dut (
      .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .mclk_en(mclk_en),
      .clk_mode(clk_mode), .mode_ms(mode_ms), .ratio_cfg(ratio_cfg),
      .over_sel(over_sel), .fs_in(fs_in), .slot_sel(slot_sel),
      .bclk_stb(bclk_stb), .fs_out(fs_out), .frame_err(frame_err),
      .slot_active(slot_active)
   );

   int checks = 0, fails = 0, cycles = 0;
   string cur_req = "R9";
   bit done = 1'b0;

   // Behavioural reference model
   logic [10:0] m_cfg = '0;
   int m_m = 0, m_q = 0, m_idx = 0;
   bit m_valid = 0;
   bit e_bclk = 0, e_fs = 0, e_err = 0, e_slot = 0;

   always @(posedge clk) begin
      logic [10:0] c;
      int mm, qq, ov;
      bit t;
      c  = {clk_mode, mode_ms, ratio_cfg, over_sel};
      mm = int'(ratio_cfg[2:0]) + 1;
      qq = int'(ratio_cfg[5:3]) + 1;
      ov = 32 + 16 * int'(over_sel);
      if (!rst_n || c != m_cfg) begin
         m_cfg = rst_n ? c : 11'd0;
         m_m = 0; m_q = 0; m_idx = 0; m_valid = 0;
         e_bclk = 0; e_fs = 0; e_err = 0; e_slot = 0;
      end else begin
         t = clk_mode ? (xtal_en && m_m == mm-1 && m_q == qq-1) : mclk_en;
         if (clk_mode && xtal_en) begin
            if (m_m == mm-1) begin
               m_m = 0;
               m_q = (m_q == qq-1) ? 0 : m_q + 1;
            end else m_m = m_m + 1;
         end
         e_bclk = t; e_fs = 0; e_err = 0;
         if (t) begin
            if (mode_ms) begin
               if (!m_valid) begin m_valid = 1; m_idx = 0; e_fs = 1; end
               else begin
                  m_idx = (m_idx == ov-1) ? 0 : m_idx + 1;
                  e_fs  = (m_idx == 0);
               end
            end else if (fs_in) begin
               e_err   = m_valid && (m_idx != ov-1);
               m_idx   = 0;
               m_valid = 1;
            end else if (m_valid) begin
               m_idx = (m_idx == ov-1) ? 0 : m_idx + 1;
            end
            e_slot = m_valid && ((m_idx / 16) == int'(slot_sel));
         end
      end
   end

   task automatic chk(string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b at cycle %0d",
                  cur_req, what, act, exp, cycles);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // Compare every cycle, away from the active edge; watchdog
   always @(posedge clk) begin
      #2;
      cycles++;
      chk("bclk_stb", bclk_stb, e_bclk);
      chk("fs_out", fs_out, e_fs);
      chk("frame_err", frame_err, e_err);
      chk("slot_active", slot_active, e_slot);
      if (cycles > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         finish_run();
      end
   end

   task automatic set_cfg(bit cm, bit ms, logic [5:0] r, logic [2:0] os,
                          bit ts, string req);
      @(negedge clk);
      clk_mode = cm; mode_ms = ms; ratio_cfg = r; over_sel = os;
      slot_sel = ts; cur_req = req;
      xtal_en = 0; mclk_en = 0; fs_in = 0;
   endtask

   // Free-running sources; fs_in toggled as noise (ignored in master roles)
   task automatic run_free(int n, int xp, int mp);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         xtal_en = (i % xp) == 0;
         mclk_en = (i % mp) == 0;
         fs_in   = ((i * 7) % 5) == 0;
      end
      @(negedge clk);
      xtal_en = 0; mclk_en = 0; fs_in = 0;
   endtask

   // Host-driven frames: one source pulse per bit, fs_in every 'period' bits
   task automatic slave_bits(int nbits, int period, bit use_x);
      for (int b = 0; b < nbits; b++) begin
         @(negedge clk);
         if (use_x) xtal_en = 1; else mclk_en = 1;
         fs_in = (b % period) == 0;
         @(negedge clk);
         xtal_en = 0; mclk_en = 0; fs_in = 0;
      end
   endtask

   int err_seen = 0;
   always @(posedge clk) begin
      #3;
      if (frame_err) err_seen++;
   end

   initial begin
      // R9: reset state
      cur_req = "R9";
      clk_mode = 1; mode_ms = 1; ratio_cfg = 6'b010_001;
      repeat (3) @(negedge clk);
      xtal_en = 1; mclk_en = 1;
      repeat (3) @(negedge clk);
      xtal_en = 0; mclk_en = 0;
      rst_n = 1;

      // R2 / R1 / R4: crystal master, M=2 Q=3, OVER=32, noisy mclk_en and fs_in
      set_cfg(1, 1, 6'b010_001, 3'd0, 0, "R2");
      run_free(700, 1, 2);
      // R7: change ratio and oversampling mid-run
      set_cfg(1, 1, 6'b001_000, 3'd1, 1, "R7");
      run_free(450, 1, 3);
      // R1: largest OVER, sparse crystal pulses
      set_cfg(1, 1, 6'b000_000, 3'd7, 1, "R1");
      run_free(600, 2, 1);
      // R3 / R4: external clock master
      set_cfg(0, 1, 6'b111_111, 3'd0, 0, "R3");
      run_free(400, 1, 3);
      set_cfg(0, 1, 6'b111_111, 3'd0, 1, "R8");
      run_free(300, 1, 1);
      // R5 / R10 / R6: external clock, host frame start
      set_cfg(0, 0, 6'd0, 3'd0, 0, "R5");
      run_free(20, 1, 2);
      slave_bits(96, 32, 0);
      cur_req = "R10";
      err_seen = 0;
      @(negedge clk);
      checks++;
      if (err_seen != 0) begin
         fails++;
         $display("FAIL R10 frame_err count: actual %0d expected 0", err_seen);
      end
      cur_req = "R6";
      slave_bits(25, 20, 0);
      slave_bits(70, 32, 0);
      @(negedge clk);
      checks++;
      if (err_seen != 2) begin
         fails++;
         $display("FAIL R6 frame_err count: actual %0d expected 2", err_seen);
      end
      // R5 / R8: crystal source, host frame start, slot 1
      set_cfg(1, 0, 6'd0, 3'd0, 1, "R8");
      slave_bits(100, 32, 1);
      // R7: switch role while frames are running
      set_cfg(1, 1, 6'd0, 3'd0, 1, "R7");
      run_free(80, 1, 1);
      set_cfg(1, 0, 6'd0, 3'd0, 0, "R7");
      slave_bits(40, 32, 1);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule